// File: doc/BRIEF.md
# Periodic Interrupt Control Register for a Real-Time Clock

This block holds one byte of real-time-clock control state and generates a periodic interrupt from it. A clock-enable strobe at the timekeeping rate (2^LOG2_HZ per second, 32.768 kHz by default) advances a free-running prescaler while the run bit is set. A three-bit select field picks one of seven binary-spaced periods, from 1/256 s to 2 s, or turns the periodic event off. Each period elapsing sets a sticky flag. While the select field is nonzero, that flag drives the interrupt request.

Software reaches the byte through a single write strobe with write data, and reads it back through a read-data bus that always shows the register. Writing the flag bit as 1 sets the flag and writing it as 0 clears it. Two self-clearing command bits are never stored. One clears the prescaler. The other emits a one-cycle request toward the calendar logic, which lies outside this block, for a 30-second adjustment.

There are two kinds of reset. The asynchronous power-on reset, which is released synchronously, loads a fixed value. The synchronous manual reset keeps the enable and run bits and clears everything else. A standby input freezes the register and the prescaler.

Top module: `rtc_pirq_ctl`

## Requirements
- R1: Power-on reset sets the read value to 0x09 (enable and run set, everything else clear), clears the prescaler, and holds irq low. The internal reset is released on the third clock edge after rst_n rises.
- R2: A cycle with man_rst high forces the flag (bit 7) and the select field (bits 6:4) to 0. It leaves the enable bit (bit 3) and the run bit (bit 0) unchanged, and it ignores any write in that cycle.
- R3: While standby is high and man_rst is low, the register and the prescaler hold their values, and bus writes, including the command bits, have no effect.
- R4: A write with bit 7 = 1 sets the flag and a write with bit 7 = 0 clears it. If a hardware period event and a write of 0 to the flag fall in the same cycle, the flag ends up set.
- R5: The select field in bits 6:4 chooses the period. Codes 1 to 7 give P = 2^LOG2_HZ × {1/256, 1/64, 1/16, 1/4, 1/2, 1, 2} ticks, and consecutive hardware flag sets are P ticks apart. After the prescaler is cleared, the first set comes after P/2 ticks.
- R6: With the select field at 000, hardware never sets the flag.
- R7: irq is high exactly when the flag is set and the select field is nonzero.
- R8: The prescaler advances by one on a clock edge only when tick is high, the run bit (bit 0) is 1, and standby is low.
- R9: Writing bit 1 as 1 clears the prescaler in that cycle. Bit 1 always reads 0.
- R10: Writing bit 2 as 1 pulses adj_pulse high for exactly the following cycle. Bit 2 always reads 0.
- R11: The read value is {flag, select[2:0], enable, 0, 0, run}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| man_rst | input | 1 | Manual reset, active high, synchronous |
| standby | input | 1 | Retention mode: freezes the register and the prescaler |
| tick | input | 1 | Clock enable at the timekeeping rate |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register read value |
| irq | output | 1 | Periodic interrupt request |
| adj_pulse | output | 1 | One-cycle 30-second-adjust request |

## Verification
The assertions assume that tick and the bus inputs change only between clock edges. They also assume that man_rst and standby are plain levels from a controller, so that either can coincide with writes or ticks in any combination. The stimulus is driven on the falling clock edge. Random phases freely overlap standby, manual reset, writes and ticks. The tap decode is exercised with LOG2_HZ set to 10, so that every period, including the 2 s one, completes several times within a short run.

// File: rtl/rtc_pirq_pkg.sv
package rtc_pirq_pkg;

  // Field positions in the control byte
  localparam int FLAG_B = 7;
  localparam int SEL_HI = 6;
  localparam int SEL_LO = 4;
  localparam int EN_B   = 3;
  localparam int ADJ_B  = 2;
  localparam int DCLR_B = 1;
  localparam int RUN_B  = 0;

  localparam int SEL_W  = SEL_HI - SEL_LO + 1;
  localparam int NCODE  = 1 << SEL_W;

  typedef logic [SEL_W-1:0] psel_t;

  localparam logic [7:0] POR_VAL = 8'h09;

  // log2 of the period relative to one second, per select code
  function automatic int per_log2_off(input int code);
    case (code)
      1:       return -8;
      2:       return -6;
      3:       return -4;
      4:       return -2;
      5:       return -1;
      6:       return 0;
      7:       return 1;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_inc,
  output logic [CNT_W-1:0] cnt_q
);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_inc = cnt_q + CNT_W'(1);
    cnt_en  = clr | adv;
    cnt_d   = clr ? '0 : cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R9
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !adv) |=> $stable(cnt_q));

  // R8
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/rtc_tap_evt.sv
module rtc_tap_evt
  import rtc_pirq_pkg::*;
#(
  parameter int LOG2_HZ = 15,
  parameter int CNT_W   = LOG2_HZ + 1
) (
  input  logic             step,
  input  psel_t            sel,
  input  logic [CNT_W-1:0] cnt_inc,
  output logic             evt
);

  logic [NCODE-1:0] hit;

  assign hit[0] = 1'b0;

  // One match term per select code: the selected tap bit rises
  // when the new count has that bit set and every bit below clear.
  for (genvar c = 1; c < NCODE; c++) begin : g_tap
    localparam int TB = LOG2_HZ + per_log2_off(c) - 1;
    assign hit[c] = cnt_inc[TB] & ~|cnt_inc[TB-1:0];
  end

  assign evt = step & hit[sel];

endmodule

// File: rtl/rtc_ctl_reg.sv
module rtc_ctl_reg
  import rtc_pirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       man_rst,
  input  logic       standby,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       hw_evt,
  output logic       flag_q,
  output psel_t      sel_q,
  output logic       en_q,
  output logic       run_q,
  output logic       clr_req,
  output logic       adj_q
);

  logic  wr_ok;
  logic  upd;
  logic  flag_d;
  psel_t sel_d;
  logic  en_d;
  logic  run_d;
  logic  adj_d;

  always_comb begin
    wr_ok   = wr & ~standby & ~man_rst;
    clr_req = wr_ok & wdata[DCLR_B];
    adj_d   = wr_ok & wdata[ADJ_B];
    upd     = man_rst | wr_ok | hw_evt;
    flag_d  = flag_q;
    sel_d   = sel_q;
    en_d    = en_q;
    run_d   = run_q;
    if (man_rst) begin
      flag_d = 1'b0;
      sel_d  = '0;
    end else begin
      if (wr_ok) begin
        flag_d = wdata[FLAG_B];
        sel_d  = wdata[SEL_HI:SEL_LO];
        en_d   = wdata[EN_B];
        run_d  = wdata[RUN_B];
      end
      if (hw_evt) flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= POR_VAL[FLAG_B];
      sel_q  <= POR_VAL[SEL_HI:SEL_LO];
      en_q   <= POR_VAL[EN_B];
      run_q  <= POR_VAL[RUN_B];
    end else if (upd) begin
      flag_q <= flag_d;
      sel_q  <= sel_d;
      en_q   <= en_d;
      run_q  <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) adj_q <= 1'b0;
    else        adj_q <= adj_d;
  end

  // R2
  mrst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    man_rst |=> (en_q == $past(en_q) && run_q == $past(run_q)
                 && !flag_q && sel_q == '0));

  // R3
  stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !man_rst) |=> $stable({flag_q, sel_q, en_q, run_q}));

  // R4
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_evt && !man_rst) |=> flag_q);

  // R10
  adj_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !standby && !man_rst && wdata[ADJ_B]) |=> adj_q);

endmodule

// File: rtl/rtc_pirq_ctl.sv
module rtc_pirq_ctl
  import rtc_pirq_pkg::*;
#(
  parameter int LOG2_HZ = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       man_rst,
  input  logic       standby,
  input  logic       tick,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       adj_pulse
);

  localparam int CNT_W = LOG2_HZ + 1;

  logic [1:0]       rst_sync;
  logic             rst_i;
  logic             flag_q;
  psel_t            sel_q;
  logic             en_q;
  logic             run_q;
  logic             clr_req;
  logic             adv;
  logic             step;
  logic             hw_evt;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_q;

  // Asynchronous assert, two-flop synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  assign adv  = tick & run_q & ~standby;
  assign step = adv & ~clr_req;

  rtc_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_i),
    .adv     (adv),
    .clr     (clr_req),
    .cnt_inc (cnt_inc),
    .cnt_q   (cnt_q)
  );

  rtc_tap_evt #(.LOG2_HZ(LOG2_HZ), .CNT_W(CNT_W)) u_tap (
    .step    (step),
    .sel     (sel_q),
    .cnt_inc (cnt_inc),
    .evt     (hw_evt)
  );

  rtc_ctl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_i),
    .man_rst (man_rst),
    .standby (standby),
    .wr      (bus_wr),
    .wdata   (bus_wdata),
    .hw_evt  (hw_evt),
    .flag_q  (flag_q),
    .sel_q   (sel_q),
    .en_q    (en_q),
    .run_q   (run_q),
    .clr_req (clr_req),
    .adj_q   (adj_pulse)
  );

  assign bus_rdata = {flag_q, sel_q, en_q, 1'b0, 1'b0, run_q};
  assign irq       = flag_q & (sel_q != '0);

  // R6
  no_evt_when_off_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (sel_q == '0 && !man_rst && !(bus_wr && !standby && bus_wdata[FLAG_B]))
      |=> !bus_rdata[FLAG_B] || $past(flag_q));

  // R7
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_i)
    irq |-> bus_rdata[FLAG_B]);

endmodule

// File: tb/tb_rtc_pirq_ctl.sv
`timescale 1ns/1ps
module tb_rtc_pirq_ctl;

  localparam int LOG2_HZ = 10;
  localparam int CMOD    = 1 << (LOG2_HZ + 1);

  logic       clk;
  logic       rst_n;
  logic       man_rst;
  logic       standby;
  logic       tick;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq;
  logic       adj_pulse;

  int checks;
  int errors;
  int cyc;
  bit done;

  rtc_pirq_ctl #(.LOG2_HZ(LOG2_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .man_rst(man_rst), .standby(standby),
    .tick(tick), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .adj_pulse(adj_pulse)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc++;

  function automatic int per(input int c);
    case (c)
      1: return (1 << LOG2_HZ) / 256;
      2: return (1 << LOG2_HZ) / 64;
      3: return (1 << LOG2_HZ) / 16;
      4: return (1 << LOG2_HZ) / 4;
      5: return (1 << LOG2_HZ) / 2;
      6: return (1 << LOG2_HZ);
      7: return (1 << LOG2_HZ) * 2;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit m_flag, m_en, m_run, m_adj;
  int m_sel, m_cnt, m_rel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag = 0; m_sel = 0; m_en = 1; m_run = 1; m_adj = 0;
      m_cnt = 0; m_rel = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      bit wok, ev;
      wok = bus_wr && !standby && !man_rst;
      ev  = 0;
      if (wok && bus_wdata[1]) m_cnt = 0;
      else if (tick && m_run && !standby) begin
        m_cnt = (m_cnt + 1) % CMOD;
        if (m_sel != 0 && (m_cnt % per(m_sel)) == per(m_sel) / 2) ev = 1;
      end
      m_adj = wok && bus_wdata[2];
      if (man_rst) begin
        m_flag = 0; m_sel = 0;
      end else if (!standby) begin
        if (wok) begin
          m_flag = bus_wdata[7]; m_sel = int'(bus_wdata[6:4]);
          m_en = bus_wdata[3]; m_run = bus_wdata[0];
        end
        if (ev) m_flag = 1;
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R11", int'(bus_rdata),
          int'({m_flag, 3'(m_sel), m_en, 2'b00, m_run}));
      chk("R7", int'(irq), int'(m_flag && m_sel != 0));
      chk("R10", int'(adj_pulse), int'(m_adj));
    end
  end

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic wait_flag(output int n, input int lim);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!bus_rdata[7] && n < lim);
  endtask

  initial begin
    int n;
    int hi;
    rst_n = 0; man_rst = 0; standby = 0; tick = 0; bus_wr = 0; bus_wdata = '0;
    checks = 0; errors = 0; cyc = 0; done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1", int'(bus_rdata), 8'h09);
    chk("R1", int'(irq), 0);

    // R4: software set and clear, select off keeps irq low
    wr_byte(8'h89);
    @(posedge clk); #1;
    chk("R4", int'(bus_rdata), 8'h89);
    chk("R7", int'(irq), 0);
    wr_byte(8'h09);
    @(posedge clk); #1;
    chk("R4", int'(bus_rdata[7]), 0);

    // R8: run bit clear stops the prescaler
    tick = 1'b1;
    wr_byte(8'h1A);
    repeat (60) @(posedge clk);
    #1;
    chk("R8", int'(bus_rdata[7]), 0);
    wr_byte(8'h19);
    wait_flag(n, 100);
    chk("R8", n, 2);

    // R5: every select code, first half period then full period
    for (int c = 1; c < 8; c++) begin
      int t0;
      wr_byte(8'((c << 4) | 8'h0B));
      wait_flag(n, 5000);
      chk("R5", n, per(c) / 2);
      t0 = cyc;
      wr_byte(8'((c << 4) | 8'h09));
      do begin @(posedge clk); #1; end while (!bus_rdata[7] && cyc - t0 < 5000);
      chk("R5", cyc - t0, per(c));
    end

    // R9: divider clear restarts the count, bit reads 0
    wr_byte(8'h7B);
    repeat (1000) @(posedge clk);
    wr_byte(8'h7B);
    #1;
    chk("R9", int'(bus_rdata[1]), 0);
    wait_flag(n, 5000);
    chk("R9", n, per(7) / 2);

    // R6: select off never sets the flag
    wr_byte(8'h0B);
    hi = 0;
    for (int i = 0; i < 2200; i++) begin
      @(posedge clk); #1;
      if (bus_rdata[7]) hi++;
    end
    chk("R6", hi, 0);

    // R4: hardware set beats a write of 0 in the same cycle
    wr_byte(8'h19);
    hi = 0;
    @(negedge clk); bus_wr = 1'b1; bus_wdata = 8'h19;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      if (bus_rdata[7]) hi++;
    end
    @(negedge clk); bus_wr = 1'b0;
    chk("R4", int'(hi > 0), 1);

    // R2: manual reset keeps enable and run only
    tick = 1'b0;
    wr_byte(8'hF8);
    @(negedge clk); man_rst = 1'b1; bus_wr = 1'b1; bus_wdata = 8'hF1;
    @(negedge clk); man_rst = 1'b0; bus_wr = 1'b0;
    #0.5;
    chk("R2", int'(bus_rdata), 8'h08);
    wr_byte(8'hA1);
    @(negedge clk); man_rst = 1'b1;
    @(negedge clk); man_rst = 1'b0;
    #0.5;
    chk("R2", int'(bus_rdata), 8'h01);

    // R3: standby freezes the register and ignores writes
    wr_byte(8'hB9);
    @(negedge clk); standby = 1'b1; tick = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h06;
    repeat (100) @(negedge clk);
    standby = 1'b0; bus_wr = 1'b0; tick = 1'b0;
    #0.5;
    chk("R3", int'(bus_rdata), 8'hB9);
    chk("R3", int'(adj_pulse), 0);

    // R10: adjust request pulse
    @(negedge clk); bus_wr = 1'b1; bus_wdata = 8'h0D;
    @(posedge clk); #1;
    chk("R10", int'(adj_pulse), 1);
    chk("R10", int'(bus_rdata[2]), 0);
    @(negedge clk); bus_wr = 1'b0;
    @(posedge clk); #1;
    chk("R10", int'(adj_pulse), 0);

    // Random mix, compared against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      tick      = 1'($urandom % 2);
      bus_wr    = ($urandom % 10) == 0;
      bus_wdata = 8'($urandom) | 8'h01;
      standby   = ($urandom % 16) == 0;
      man_rst   = ($urandom % 80) == 0;
    end
    @(negedge clk);
    bus_wr = 0; standby = 0; man_rst = 0; tick = 0;

    // R1: power-on reset in mid-run
    wr_byte(8'hF8);
    @(negedge clk); rst_n = 1'b0;
    #0.5;
    chk("R1", int'(bus_rdata), 8'h09);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1", int'(bus_rdata), 8'h09);
    chk("R1", int'(irq), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule